// File: doc/BRIEF.md
# Platform Interrupt Priority Arbiter

This block is the core of a platform-level interrupt controller. It latches requests from `NUM_SRC` interrupt sources into pending bits, and serves a set of contexts. Each context is one (hart, privilege mode) target. For every context it selects the highest-priority eligible source and drives one registered interrupt line toward that context. A machine-mode context feeds the machine external interrupt input of its hart. A supervisor-mode context feeds the supervisor external interrupt input.

A simple synchronous word-addressed register port holds everything software sees:
- one priority per source;
- the packed pending bits;
- one enable bit per source for each context;
- one threshold per context;
- one claim/complete register per context.

Reading a claim register hands the winning source to software and holds that source off. Writing the same ID back to the complete register lets the source request again.

The mapping from contexts to harts can come from either of two places. One is an explicit parameter table, which lets a hart own only a machine context. The other is a legacy layout of two contexts per hart. Exactly one of the two must be chosen.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, every context line and hart line is low, all priorities, enables and thresholds read 0, no pending bit is set, and every claim register returns 0.
- R2: A high level on source i (1 <= i < NUM_SRC) at a clock edge sets its pending bit unless the source is held. The bit stays set until the source is claimed. Pending bits read at word address 0x100+w, bit b being source 32*w+b. Source 0 never becomes pending.
- R3: Source i is eligible for context c only when three conditions hold: it is pending, its enable bit is set for context c, and its priority is nonzero. The priority of source i sits at word address i (low PRIO_W bits). The enable bit of source i for context c is bit i%32 of word 0x200+16*c+i/32. A priority written to a pending source applies from the next cycle. A priority written to a non-pending source changes no winner.
- R4: Reading the claim register of context c (address 0x401+2*c) returns the eligible source with the largest priority. Among equal priorities, the lowest ID is returned. The read returns 0 when no source is eligible.
- R5: The line of context c is high only when the winning priority is strictly greater than that context's threshold. The threshold is read and written at 0x400+2*c.
- R6: A context line reflects the register and pending state one clock edge after the edge that updated that state. A source raised before edge t therefore moves the line at edge t+1.
- R7: A claim read with a nonzero result clears that source's pending bit at the same edge. The source then cannot become pending until its ID is written to a complete register. After that write, a new request latches again.
- R8: Writing a complete register with an ID other than the held one leaves the held source blocked.
- R9: With the parameter table, context c drives hart entry c of `CTX_HART_TBL` (8 bits per context). It drives the supervisor line when bit c of `CTX_SMODE` is set, and the machine line otherwise. Default: context 0 is hart 0 machine, context 1 is hart 1 machine, context 2 is hart 1 supervisor.
- R10: With `LEGACY_HARTS`=K>0 there are 2K contexts. Context 2k drives hart k's machine line and context 2k+1 drives its supervisor line. Choosing both the legacy count and the table, or neither, stops elaboration with an error.
- R11: Writes to the priority of source 0 are ignored, and it always reads 0. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NUM_SRC | Source request levels; bit 0 is unused |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (side effect only on claim) |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| ctx_line | output | NCTX | Registered interrupt line per context |
| hart_mei | output | NUM_HART | Machine external interrupt per hart |
| hart_sei | output | NUM_HART | Supervisor external interrupt per hart |

## Verification
Read data, including claim results, is combinational on the current state. The bench samples it one time step after driving the address, before the next edge. A claim, write or source request changes state at the following edge, and a context line changes only one edge later. The bench therefore checks each line right after the state-changing edge, where the old value must still hold, and again after one idle cycle, where the new value is due. All stimulus is driven on the falling edge, so no sample coincides with an active edge.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int MAX_CTX   = 16;
    localparam int MAX_WORDS = 16;

    // address page selectors (word addresses)
    localparam logic [3:0] PAGE_PRIO = 4'h0;
    localparam logic [3:0] PAGE_PEND = 4'h1;
    localparam logic [2:0] BANK_EN   = 3'd1;
    localparam logic [2:0] BANK_CTX  = 3'd2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PRIO,
        SEL_PEND,
        SEL_EN,
        SEL_THR,
        SEL_CLAIM
    } sel_e;

endpackage

// File: rtl/ipa_gateway.sv
module ipa_gateway #(
    parameter int NUM_SRC = 40,
    parameter int ID_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic               claim_fire,
    input  logic [ID_W-1:0]    claim_id,
    input  logic               done_fire,
    input  logic [ID_W-1:0]    done_id,
    output logic [NUM_SRC-1:0] pend
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] held;
    } gw_t;

    gw_t gw_d, gw_q;

    always_comb begin
        gw_d = gw_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            logic hit_claim;
            logic hit_done;
            hit_claim = claim_fire && (int'(claim_id) == i) && (i != 0);
            hit_done  = done_fire && (int'(done_id) == i);
            if (hit_claim) begin
                gw_d.pend[i] = 1'b0;
                gw_d.held[i] = 1'b1;
            end else if (hit_done) begin
                gw_d.held[i] = 1'b0;
            end
            if ((i != 0) && src[i] && !hit_claim && !gw_d.held[i])
                gw_d.pend[i] = 1'b1;
            if (i == 0) begin
                gw_d.pend[i] = 1'b0;
                gw_d.held[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gw_q <= '0;
        else        gw_q <= gw_d;
    end

    assign pend = gw_q.pend;

    for (genvar g = 1; g < NUM_SRC; g++) begin : g_chk
        // R7: a held source is never pending
        p_held_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
            gw_q.held[g] |-> !gw_q.pend[g]);
        // R2: pending is sticky until that source is claimed
        p_pend_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (gw_q.pend[g] && !(claim_fire && int'(claim_id) == g)) |=> gw_q.pend[g]);
    end

endmodule

// File: rtl/ipa_winner.sv
module ipa_winner #(
    parameter int NUM_SRC = 40,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 6
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0]             en,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output logic [ID_W-1:0]                win_id,
    output logic [PRIO_W-1:0]              win_prio
);

    // Linear scan: strict comparison keeps the lowest ID on a tie,
    // and a zero start value excludes priority-0 sources.
    always_comb begin
        win_id   = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if ((i != 0) && pend[i] && en[i] && (prio[i] > win_prio)) begin
                win_prio = prio[i];
                win_id   = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/ipa_route.sv
module ipa_route #(
    parameter int                 NCTX         = 3,
    parameter int                 NUM_HART     = 2,
    parameter int                 LEGACY_HARTS = 0,
    parameter logic [16*8-1:0]    HART_TBL     = '0,
    parameter logic [15:0]        SMODE        = '0
) (
    input  logic [NCTX-1:0]     line,
    output logic [NUM_HART-1:0] mei,
    output logic [NUM_HART-1:0] sei
);

    if (LEGACY_HARTS > 0) begin : g_pairs
        always_comb begin
            mei = '0;
            sei = '0;
            for (int c = 0; c < NCTX; c++) begin
                if ((c / 2) < NUM_HART) begin
                    if ((c % 2) == 1) sei[c / 2] = sei[c / 2] | line[c];
                    else              mei[c / 2] = mei[c / 2] | line[c];
                end
            end
        end
    end else begin : g_table
        always_comb begin
            mei = '0;
            sei = '0;
            for (int c = 0; c < NCTX; c++) begin
                int h;
                h = int'(HART_TBL[8*c +: 8]);
                if (h < NUM_HART) begin
                    if (SMODE[c]) sei[h] = sei[h] | line[c];
                    else          mei[h] = mei[h] | line[c];
                end
            end
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import ipa_pkg::*;
#(
    parameter int              NUM_SRC      = 40,
    parameter int              PRIO_W       = 3,
    parameter int              NUM_HART     = 2,
    parameter int              NUM_CTX      = 3,
    parameter logic [16*8-1:0] CTX_HART_TBL = 128'h01_01_00,
    parameter logic [15:0]     CTX_SMODE    = 16'h0004,
    parameter bit              TABLE_GIVEN  = 1'b1,
    parameter int              LEGACY_HARTS = 0,
    localparam int             NCTX         = (LEGACY_HARTS > 0) ? 2 * LEGACY_HARTS : NUM_CTX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_irq,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NCTX-1:0]     ctx_line,
    output logic [NUM_HART-1:0] hart_mei,
    output logic [NUM_HART-1:0] hart_sei
);

    localparam int NWORDS = (NUM_SRC + 31) / 32;
    localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    // configuration sanity: exactly one context source
    if (TABLE_GIVEN && LEGACY_HARTS != 0) begin : g_cfg_both
        $error("irq_prio_arbiter: legacy hart count and context table both set");
    end
    if (!TABLE_GIVEN && LEGACY_HARTS == 0) begin : g_cfg_none
        $error("irq_prio_arbiter: no context layout selected");
    end
    if (NCTX > MAX_CTX || NWORDS > MAX_WORDS) begin : g_cfg_size
        $error("irq_prio_arbiter: context or source count exceeds address map");
    end

    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NCTX-1:0][NUM_SRC-1:0]   en;
        logic [NCTX-1:0][PRIO_W-1:0]    thr;
        logic [NCTX-1:0]                line;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0]           pend;
    logic [NCTX-1:0][ID_W-1:0]    win_id;
    logic [NCTX-1:0][PRIO_W-1:0]  win_prio;

    sel_e            sel;
    int              src_idx;
    int              word_idx;
    int              en_ctx;
    int              en_word;
    int              cx;
    logic            claim_fire;
    logic [ID_W-1:0] claim_id;
    logic            done_fire;
    logic [ID_W-1:0] done_id;

    // ---------------- address decode ----------------
    always_comb begin
        src_idx  = int'(bus_addr[7:0]);
        word_idx = int'(bus_addr[7:0]);
        en_ctx   = int'(bus_addr[8:4]);
        en_word  = int'(bus_addr[3:0]);
        cx       = int'(bus_addr[8:1]);
        sel      = SEL_NONE;
        if (bus_addr[11:8] == PAGE_PRIO && src_idx < NUM_SRC)
            sel = SEL_PRIO;
        else if (bus_addr[11:8] == PAGE_PEND && word_idx < NWORDS)
            sel = SEL_PEND;
        else if (bus_addr[11:9] == BANK_EN && en_ctx < NCTX && en_word < NWORDS)
            sel = SEL_EN;
        else if (bus_addr[11:9] == BANK_CTX && cx < NCTX)
            sel = bus_addr[0] ? SEL_CLAIM : SEL_THR;
    end

    // ---------------- claim / complete strobes ----------------
    always_comb begin
        claim_fire = bus_re && (sel == SEL_CLAIM);
        claim_id   = (sel == SEL_CLAIM) ? win_id[cx] : '0;
        done_fire  = bus_we && (sel == SEL_CLAIM) &&
                     (bus_wdata < 32'(NUM_SRC)) && (bus_wdata != '0);
        done_id    = bus_wdata[ID_W-1:0];
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            case (sel)
                SEL_PRIO: begin
                    if (src_idx != 0)
                        st_d.prio[src_idx] = bus_wdata[PRIO_W-1:0];
                end
                SEL_EN: begin
                    for (int b = 0; b < 32; b++) begin
                        if (en_word * 32 + b < NUM_SRC)
                            st_d.en[en_ctx][en_word * 32 + b] = bus_wdata[b];
                    end
                end
                SEL_THR: st_d.thr[cx] = bus_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
        for (int c = 0; c < NCTX; c++)
            st_d.line[c] = win_prio[c] > st_q.thr[c];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_PRIO: bus_rdata = 32'(st_q.prio[src_idx]);
            SEL_PEND: begin
                for (int b = 0; b < 32; b++)
                    if (word_idx * 32 + b < NUM_SRC)
                        bus_rdata[b] = pend[word_idx * 32 + b];
            end
            SEL_EN: begin
                for (int b = 0; b < 32; b++)
                    if (en_word * 32 + b < NUM_SRC)
                        bus_rdata[b] = st_q.en[en_ctx][en_word * 32 + b];
            end
            SEL_THR:   bus_rdata = 32'(st_q.thr[cx]);
            SEL_CLAIM: bus_rdata = 32'(win_id[cx]);
            default:   bus_rdata = '0;
        endcase
    end

    // ---------------- submodules ----------------
    ipa_gateway #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (src_irq),
        .claim_fire (claim_fire),
        .claim_id   (claim_id),
        .done_fire  (done_fire),
        .done_id    (done_id),
        .pend       (pend)
    );

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        ipa_winner #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_win (
            .pend     (pend),
            .en       (st_q.en[c]),
            .prio     (st_q.prio),
            .win_id   (win_id[c]),
            .win_prio (win_prio[c])
        );

        // R4: a reported winner is pending, enabled here and carries its priority
        p_winner_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (win_id[c] != '0) |-> (pend[win_id[c]] && st_q.en[c][win_id[c]] &&
                                   st_q.prio[win_id[c]] == win_prio[c] &&
                                   win_prio[c] != '0));
        // R5: a raised line always had a winner one cycle earlier
        p_line_has_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.line[c] |-> ($past(win_id[c]) != '0));
    end

    ipa_route #(
        .NCTX         (NCTX),
        .NUM_HART     (NUM_HART),
        .LEGACY_HARTS (LEGACY_HARTS),
        .HART_TBL     (CTX_HART_TBL),
        .SMODE        (CTX_SMODE)
    ) u_route (
        .line (st_q.line),
        .mei  (hart_mei),
        .sei  (hart_sei)
    );

    assign ctx_line = st_q.line;

    // R7: a nonzero claim clears the claimed pending bit at that edge
    p_claim_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_fire && claim_id != '0) |=> !pend[$past(claim_id)]);

endmodule

// File: tb/irq_prio_arbiter_test.sv
`timescale 1ns/1ps
module irq_prio_arbiter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] src = '0;
    logic [39:0] lsrc = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, lrdata;
    logic [2:0]  line;
    logic [1:0]  mei, sei;
    logic [3:0]  lline;
    logic [1:0]  lmei, lsei;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    irq_prio_arbiter uut (
        .clk(clk), .rst_n(rst_n), .src_irq(src), .bus_we(we), .bus_re(re),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .ctx_line(line), .hart_mei(mei), .hart_sei(sei));

    irq_prio_arbiter #(.TABLE_GIVEN(1'b0), .LEGACY_HARTS(2)) u_leg (
        .clk(clk), .rst_n(rst_n), .src_irq(lsrc), .bus_we(we), .bus_re(re),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(lrdata),
        .ctx_line(lline), .hart_mei(lmei), .hart_sei(lsei));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input bit leg, output logic [31:0] d);
        re = 1'b1; addr = a;
        #1 d = leg ? lrdata : rdata;
        @(posedge clk);
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic pulse(input int id);
        src[id] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        src[id] = 1'b0;
    endtask

    function automatic logic [11:0] a_pend(input int w);  return 12'(32'h100 + w); endfunction
    function automatic logic [11:0] a_en(input int c, input int w); return 12'(32'h200 + 16*c + w); endfunction
    function automatic logic [11:0] a_thr(input int c);   return 12'(32'h400 + 2*c); endfunction
    function automatic logic [11:0] a_clm(input int c);   return 12'(32'h401 + 2*c); endfunction

    initial begin
        #(5.0 * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // ---- R1 reset state ----
        chk("R1 lines", 32'(line), 0);
        chk("R1 mei", 32'(mei), 0);
        chk("R1 sei", 32'(sei), 0);
        for (int c = 0; c < 3; c++) begin
            rd(a_clm(c), 0, v); chk("R1 claim", v, 0);
            rd(a_thr(c), 0, v); chk("R1 thr", v, 0);
        end
        rd(a_pend(0), 0, v); chk("R1 pend0", v, 0);
        rd(a_pend(1), 0, v); chk("R1 pend1", v, 0);
        rd(12'd7, 0, v);     chk("R1 prio", v, 0);

        // ---- sweep every source on context 0 ----
        for (int id = 1; id < 40; id++) wr(12'(id), 32'(id % 7 + 1));
        wr(a_en(0, 0), 32'hFFFF_FFFF);
        wr(a_en(0, 1), 32'hFFFF_FFFF);
        for (int id = 1; id < 40; id++) begin
            pulse(id);
            chk("R6 line not yet", 32'(line), 0);
            idle(1);
            rd(a_pend(id / 32), 0, v); chk("R2 pend word", v, 32'(1) << (id % 32));
            chk("R5 line ctx0", 32'(line), 32'b001);
            chk("R9 mei hart0", 32'(mei), 32'b01);
            rd(a_clm(0), 0, v); chk("R4 claim id", v, 32'(id));
            idle(1);
            chk("R7 line after claim", 32'(line), 0);
            pulse(id); idle(1);
            rd(a_pend(id / 32), 0, v); chk("R7 held", v, 0);
            wr(a_clm(0), 32'(id));
            pulse(id); idle(1);
            rd(a_pend(id / 32), 0, v); chk("R7 re-pend", v, 32'(1) << (id % 32));
            rd(a_clm(0), 0, v); chk("R7 second claim", v, 32'(id));
            wr(a_clm(0), 32'(id));
        end

        // ---- ties, priority changes, enable masks on context 1 ----
        wr(a_en(1, 0), 32'hFFFF_FFFF);
        wr(a_en(1, 1), 32'hFFFF_FFFF);
        wr(12'd5, 4); wr(12'd9, 4); wr(12'd33, 4);
        pulse(5); pulse(9); pulse(33); idle(1);
        chk("R5 line ctx1", 32'(line[1]), 1);
        rd(a_clm(1), 0, v); chk("R4 tie lowest", v, 5);
        wr(a_clm(1), 5);
        wr(12'd33, 6);
        rd(a_clm(1), 0, v); chk("R3 raised prio wins", v, 33);
        wr(a_clm(1), 33);
        wr(12'd9, 0);
        rd(a_clm(1), 0, v); chk("R3 zero prio ineligible", v, 0);
        idle(1);
        chk("R4 no winner line", 32'(line[1]), 0);
        wr(12'd9, 2);
        rd(a_clm(1), 0, v); chk("R3 prio applies", v, 9);
        wr(a_clm(1), 9);
        wr(a_en(1, 0), ~32'h20);
        pulse(5); pulse(9); idle(1);
        rd(a_clm(1), 0, v); chk("R3 disabled skipped", v, 9);
        rd(a_clm(0), 0, v); chk("R3 other ctx sees it", v, 5);
        wr(a_clm(1), 9); wr(a_clm(0), 5);
        wr(12'd7, 7);
        rd(a_clm(1), 0, v); chk("R3 nonpending prio", v, 0);

        // ---- wrong complete ----
        pulse(20); idle(1);
        rd(a_clm(0), 0, v); chk("R8 claim", v, 20);
        wr(a_clm(0), 21);
        pulse(20); idle(1);
        rd(a_pend(0), 0, v); chk("R8 still held", v, 0);
        wr(a_clm(0), 20);
        pulse(20); idle(1);
        rd(a_pend(0), 0, v); chk("R8 released", v, 32'(1) << 20);
        rd(a_clm(0), 0, v); wr(a_clm(0), 20);

        // ---- threshold sweep on context 2 (hart 1 supervisor) ----
        wr(a_en(2, 0), 32'(1) << 12);
        wr(12'd12, 5);
        pulse(12); idle(1);
        for (int t = 0; t < 8; t++) begin
            wr(a_thr(2), 32'(t));
            if (t > 0) chk("R6 line holds old", 32'(line[2]), 32'(5 > t - 1));
            idle(1);
            chk("R5 thr gate", 32'(line[2]), 32'(5 > t));
            chk("R9 sei hart1", 32'(sei[1]), 32'(5 > t));
            chk("R9 sei hart0", 32'(sei[0]), 0);
            rd(a_thr(2), 0, v); chk("R5 thr readback", v, 32'(t));
        end
        rd(a_clm(2), 0, v); chk("R4 claim ctx2", v, 12);
        wr(a_clm(2), 12);
        wr(a_thr(2), 0);
        idle(1);
        chk("R9 mei hart1 idle", 32'(mei[1]), 0);

        // ---- source 0 and unmapped ----
        pulse(0); idle(1);
        rd(a_pend(0), 0, v); chk("R2 src0 never pending", v, 0);
        chk("R2 src0 no line", 32'(line), 0);
        wr(12'd0, 7);
        rd(12'd0, 0, v); chk("R11 prio0 zero", v, 0);
        rd(12'hFFF, 0, v); chk("R11 unmapped", v, 0);

        // ---- legacy layout instance ----
        wr(a_en(1, 0), 0); wr(a_en(1, 1), 0); wr(a_en(2, 0), 0);
        wr(a_en(3, 0), 32'(1) << 3);
        lsrc[3] = 1'b1; idle(1); lsrc[3] = 1'b0; idle(1);
        chk("R10 legacy lines", 32'(lline), 32'b1001);
        chk("R10 legacy mei", 32'(lmei), 32'b01);
        chk("R10 legacy sei", 32'(lsei), 32'b10);
        wr(a_en(2, 0), 32'(1) << 3);
        idle(1);
        chk("R10 legacy ctx2 machine", 32'(lmei), 32'b11);
        chk("R10 legacy lines 2", 32'(lline), 32'b1101);
        rd(a_clm(3), 1, v); chk("R10 legacy claim", v, 3);

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule